// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by counting upward in a 16-bit register that software must service before the register passes its all-ones value. A prescaler sits in front of the counter. It divides either the system clock or a slow wake-up clock by one of two ratios. The wake-up clock arrives as a plain input and is sampled into the system clock domain, so the counter itself runs in a single clock domain. Each legal service copies a programmable reload value into the counter and restarts the prescaler from zero.

The block also has a lower service boundary. A service that arrives while the counter is still below the programmed window value counts as a fault, just like a missed service. Either fault raises a reset request. The request holds until the block's own reset. A two-bit cause field shows which fault came first.

Configuration uses a small write port. Address 0 holds the reload value and address 1 the window boundary. Address 2 is control, and a write to address 3 is a service strobe. Once the enabled watchdog has been legally serviced, configuration is frozen for as long as it stays enabled.

Top module: `wdt_window`

## Requirements
- R1: While enabled, the counter rises by exactly one for each completed prescaler period. While disabled, the counter and the prescaler hold, and no reset request appears.
- R2: Control bit 2 selects the prescale ratio: 0 divides by 256 and 1 divides by 16384.
- R3: Control bit 1 selects the count source: 0 is every system clock cycle and 1 is each rising edge of `wu_clk`, seen through a synchronizer.
- R4: A legal service (write to address 3) loads the counter from the reload register and clears the prescaler. With ratio D and reload R, the reset request rises D*(65536-R) clock edges after the edge that registers the service.
- R5: A counter advance from 16'hFFFF raises `rst_req` and sets `fault` to 2'b01.
- R6: A service while enabled and with the counter strictly below the window value raises `rst_req` on the next edge and sets `fault` to 2'b10.
- R7: `rst_req` and `fault` stay fixed until `rst_n` is asserted. Later services and writes change nothing, and only the first cause is recorded.
- R8: After reset, `rst_req` is 0 and `fault` is 2'b00. Reload and counter are 16'hFF00, the window is 0, and the block is enabled on the wake-up source at ratio 256.
- R9: Writes to addresses 0, 1 and 2 are ignored after the first legal service made while enabled, for as long as the block is enabled. This includes a write that would disable it. A service while disabled reloads without the window check and does not freeze the configuration.
- R10: A service registered on the same edge as the counter's advance from 16'hFFFF wins: no fault, and the counter reloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, the only way to clear a reset request |
| wu_clk | input | 1 | Slow wake-up clock, asynchronous to `clk` |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 2 | 0 reload, 1 window, 2 control {ratio, source, enable}, 3 service |
| wr_data | input | 16 | Write data |
| rst_req | output | 1 | Sticky reset request |
| fault | output | 2 | Cause: bit 0 overflow, bit 1 early service |

## Verification
Two events can meet on one clock edge: a service strobe and the prescaler tick that would carry the counter past 16'hFFFF. The bench times a service to land exactly on the edge of the expected overflow, 256*(65536-R) edges after enabling. It then checks that no request appears and that a full fresh interval follows. Random trials place services at chosen counter values around a random window boundary, so a service can be compared both against the boundary and against an imminent counter advance.

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int          CW         = 16,
  parameter int          DIV_LO     = 256,
  parameter int          DIV_HI     = 16384,
  parameter logic [15:0] RELOAD_RST = 16'hFF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wu_clk,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          rst_req,
  output logic [1:0]    fault
);
  localparam int PW = $clog2(DIV_HI);

  logic [CW-1:0] reload, window, cnt;
  logic [PW-1:0] presc;
  logic          en, src_sel, div_sel, locked;
  logic [2:0]    wu_sync;

  wire          svc      = wr_en && (wr_addr == 2'd3) && !rst_req;
  wire          cfg_wr   = wr_en && (wr_addr != 2'd3) && !rst_req && (!locked || !en);
  wire          src_tick = src_sel ? (wu_sync[1] && !wu_sync[2]) : 1'b1;
  wire [PW-1:0] div_last = div_sel ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
  wire          pre_done = en && src_tick && (presc >= div_last);
  wire          bad_svc  = svc && en && (cnt < window);
  wire          good_svc = svc && !bad_svc;
  wire          ovf      = pre_done && (&cnt) && !svc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wu_sync <= '0;
    else        wu_sync <= {wu_sync[1:0], wu_clk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload  <= CW'(RELOAD_RST);
      window  <= '0;
      cnt     <= CW'(RELOAD_RST);
      presc   <= '0;
      en      <= 1'b1;
      src_sel <= 1'b1;
      div_sel <= 1'b0;
      locked  <= 1'b0;
      rst_req <= 1'b0;
      fault   <= 2'b00;
    end else if (!rst_req) begin
      if (cfg_wr)
        case (wr_addr)
          2'd0:    reload <= wr_data;
          2'd1:    window <= wr_data;
          default: {div_sel, src_sel, en} <= wr_data[2:0];
        endcase
      if (good_svc) begin
        cnt   <= reload;
        presc <= '0;
        if (en) locked <= 1'b1;
      end else if (en && src_tick) begin
        presc <= pre_done ? '0 : presc + 1'b1;
        if (pre_done) cnt <= cnt + 1'b1;
      end
      if (bad_svc) begin
        rst_req <= 1'b1;
        fault   <= 2'b10;
      end else if (ovf) begin
        rst_req <= 1'b1;
        fault   <= 2'b01;
      end
    end
  end
endmodule

module wdt_window_chk #(parameter int CW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_req,
  input logic [1:0]    fault,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] reload,
  input logic [CW-1:0] window,
  input logic          en,
  input logic          svc,
  input logic          pre_done
);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req && $stable(fault));
  assert_one_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault) && (rst_req == (fault != 2'b00)));
  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && en && (cnt < window)) |=> rst_req && (fault == 2'b10));
  assert_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && pre_done && (&cnt) && !svc) |=> rst_req && (fault == 2'b01));
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && !(en && (cnt < window))) |=> !rst_req && (cnt == $past(reload)));
  assert_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && !svc && pre_done && !(&cnt)) |=> cnt == CW'($past(cnt) + 1'b1));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && !svc && !en) |=> $stable(cnt) && !rst_req);
endmodule

bind wdt_window wdt_window_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .fault(fault), .cnt(cnt),
  .reload(reload), .window(window), .en(en), .svc(svc), .pre_done(pre_done));

// File: tb/wdt_window_tb.sv
`timescale 1ns/1ps
module wdt_window_tb;
  logic clk = 0, rst_n = 0, wu_clk = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic rst_req;
  logic [1:0] fault;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;
  always #20 wu_clk = ~wu_clk;

  wdt_window u_dut (.clk(clk), .rst_n(rst_n), .wu_clk(wu_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rst_req(rst_req), .fault(fault));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int interval(input int ratio, input logic [15:0] r);
    return ratio * (65536 - int'(r));
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic measure(input int limit, output int n);
    n = 0;
    while (!rst_req && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic setup(input logic [15:0] r, input logic [15:0] w, input logic [2:0] ctrl);
    do_reset();
    wr(2, 16'd0);
    wr(0, r);
    wr(1, w);
    wr(3, 16'd0);
    wr(2, {13'd0, ctrl});
  endtask

  initial begin
    #(4 * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    chk(rst_req == 0 && fault == 0, "R8 reset outputs", {rst_req, fault}, 0);

    // R8 R3: default wake-up source and ratio 256, only reload changed
    wr(0, 16'hFFFE);
    wr(3, 16'd0);
    measure(20000, n);
    chk(n >= 5120 - 40 && n <= 5120 + 40, "R3 R8 wake-up interval", n, 5120);
    chk(fault == 2'b01, "R5 overflow cause", fault, 1);

    // R2: ratio 16384 on system clock
    setup(16'hFFFF, 16'd0, 3'b101);
    measure(40000, n);
    chk(n == 16384, "R2 divide 16384", n, 16384);

    // R4 R5: system clock ratio 256
    setup(16'hFFF8, 16'd0, 3'b001);
    measure(20000, n);
    chk(n == interval(256, 16'hFFF8), "R4 overflow interval", n, interval(256, 16'hFFF8));
    chk(fault == 2'b01 && rst_req, "R5 overflow flag", fault, 1);
    wr(3, 16'd0); wr(1, 16'hFFFF); repeat (300) @(negedge clk);
    chk(fault == 2'b01 && rst_req, "R7 sticky after overflow", fault, 1);

    // R9: configuration frozen after a legal service
    setup(16'hFFF8, 16'd0, 3'b001);
    repeat (99) @(negedge clk);
    wr(3, 16'd0);
    wr(0, 16'hFFF0);
    wr(2, 16'd0);
    wr(1, 16'hFFFF);
    wr(3, 16'd0);
    chk(rst_req == 0, "R9 window write ignored", rst_req, 0);
    measure(20000, n);
    chk(n == interval(256, 16'hFFF8), "R9 reload and disable ignored", n, interval(256, 16'hFFF8));

    // R1: disabled holds, enabling resumes
    setup(16'hFFFF, 16'd0, 3'b000);
    repeat (2000) @(negedge clk);
    chk(rst_req == 0, "R1 disabled holds", rst_req, 0);
    wr(2, 16'd1);
    measure(20000, n);
    chk(n == 256, "R1 resume from held count", n, 256);

    // R10: service on the overflow edge
    setup(16'hFFFC, 16'd0, 3'b001);
    repeat (interval(256, 16'hFFFC) - 2) @(negedge clk);
    wr(3, 16'd0);
    chk(rst_req == 0, "R10 service wins over overflow", rst_req, 0);
    measure(20000, n);
    chk(n == interval(256, 16'hFFFC), "R10 fresh interval", n, interval(256, 16'hFFFC));

    // R6 R4: random window trials
    for (int t = 0; t < 20; t++) begin
      int ticks = 1 + int'($urandom % 8);
      logic [15:0] r = 16'(65536 - ticks);
      logic [15:0] w = 16'(int'(r) + int'($urandom % ticks));
      int k = int'($urandom % ticks);
      bit early = (int'(r) + k) < int'(w);
      if (t == 0) begin k = 0; w = r + 16'd1; early = 1; end
      if (t == 1) begin k = 0; w = r; early = 0; end
      setup(r, w, 3'b001);
      repeat (256 * k + 99) @(negedge clk);
      wr(3, 16'd0);
      if (early) begin
        chk(rst_req && fault == 2'b10, "R6 early service fault", fault, 2);
        wr(2, 16'd0); wr(3, 16'd0); repeat (20) @(negedge clk);
        chk(rst_req && fault == 2'b10, "R7 sticky window fault", fault, 2);
      end else begin
        chk(rst_req == 0, "R6 legal service", rst_req, 0);
        measure(20000, n);
        chk(n == interval(256, r) && fault == 2'b01, "R4 reload on service", n, interval(256, r));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule